// File: doc/BRIEF.md
# Serial Receive Error Status Register

This block keeps the per-character error status of one receive channel in a multiprotocol serial controller. The deframer reports each received character with a one-cycle strobe. Alongside that strobe it reports whether the parity check failed, whether the character overran the receive buffer, whether it closed a frame, and a 3-bit residue code. The block folds these events into a status byte that stays readable at all times. It also produces a special-receive-condition flag that travels with each character's status-valid strobe.

The parity error bit and the special condition are sticky. Once set, they hold across every later character until an Error Reset command clears them. The residue field keeps a fixed idle code of 011 unless the channel runs in SDLC mode. The all-sent bit follows the transmitter's idle indication in asynchronous mode and is held high in the other modes.

Top module: `rx_err_status`

## Requirements
- R1: The parity error bit (status bit 4) is set by a received character with `rx_par_bad`=1 only while `par_en`=1. With `par_en`=0 such a character leaves bit 4 unchanged.
- R2: Once set, the parity error bit stays set through later characters and idle cycles. It clears in the cycle after an `err_reset` pulse.
- R3: With `par_special_en`=1, a character with a parity error raises `special_cond` on its own status strobe and on every later strobe until `err_reset`. With `par_special_en`=0 a parity error raises no special condition.
- R4: A character with `rx_overrun`=1 raises `special_cond` on its own strobe and on every later strobe until `err_reset`.
- R5: When `err_reset` and a new parity or overrun event arrive in the same cycle, the new event wins and the affected bit stays set.
- R6: Hardware reset `rst` and channel reset `chan_rst` both clear the parity bit and the special condition, and both load the residue field with 011. After `rst`, the status byte reads 0x07 and `stat_valid` is 0.
- R7: `mode` encodes 00 as asynchronous, 01 as synchronous, 10 as SDLC and 11 as synchronous. Outside SDLC the residue field (status bits 3:1, bit 3 the MSB) is forced to 011. In SDLC, a character with `rx_eof`=1 loads `rx_residue`, and a character without end of frame loads 011.
- R8: In asynchronous mode the all-sent bit (status bit 0) follows `tx_idle` one cycle later. In any other mode it reads 1.
- R9: The status byte holds parity error at bit 4, residue at bits 3:1 and all-sent at bit 0. Bits 7:5 read 0.
- R10: `stat_valid` pulses for one cycle, one clock after each `rx_char_valid`. `special_cond` is 0 whenever `stat_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous hardware reset, active high |
| chan_rst | input | 1 | Synchronous channel reset, active high |
| mode | input | 2 | Channel mode: 00 async, 01 sync, 10 SDLC, 11 sync |
| par_en | input | 1 | Parity checking enabled |
| par_special_en | input | 1 | Parity error counts as a special condition |
| err_reset | input | 1 | Error Reset command pulse |
| rx_char_valid | input | 1 | One-cycle strobe for a received character |
| rx_par_bad | input | 1 | Parity mismatch on this character |
| rx_overrun | input | 1 | Overrun on this character |
| rx_eof | input | 1 | This character ends a frame |
| rx_residue | input | 3 | Residue code from the deframer |
| tx_idle | input | 1 | Transmitter output fully drained |
| status | output | 8 | Status byte |
| stat_valid | output | 1 | Strobe marking status of the latest character |
| special_cond | output | 1 | Special receive condition for the strobed character |

## Verification
Every result here is one register away from its cause. A character strobed in one cycle shows its parity bit, residue, `stat_valid` and `special_cond` after the next rising edge. An `err_reset` pulse, a mode change or a `tx_idle` change likewise shows one edge later. The bench drives every input on the falling edge, holds it for one full period, and samples on the following falling edge, so every check sees the value settled after exactly one rising edge. Sticky behaviour is checked by sampling again on later clean characters and idle cycles before any reset.

// File: rtl/rx_stat_pkg.sv
package rx_stat_pkg;

    localparam int RES_W    = 3;
    localparam int STAT_W   = 8;
    localparam logic [RES_W-1:0] RES_IDLE = 3'b011;

    typedef enum logic [1:0] {
        MODE_ASYNC = 2'b00,
        MODE_SYNC  = 2'b01,
        MODE_SDLC  = 2'b10,
        MODE_SYNC2 = 2'b11
    } chan_mode_e;

    typedef struct packed {
        logic [2:0]       zero;
        logic             par_err;
        logic [RES_W-1:0] residue;
        logic             all_sent;
    } stat_byte_t;

    function automatic stat_byte_t pack_status(input logic par,
                                               input logic [RES_W-1:0] res,
                                               input logic sent);
        stat_byte_t s;
        s.zero     = '0;
        s.par_err  = par;
        s.residue  = res;
        s.all_sent = sent;
        return s;
    endfunction

endpackage

// File: rtl/rx_err_latch.sv
module rx_err_latch (
    input  logic clk,
    input  logic rst,
    input  logic chan_rst,
    input  logic err_reset,
    input  logic char_valid,
    input  logic par_en,
    input  logic par_bad,
    input  logic par_spec_en,
    input  logic overrun,
    output logic par_q,
    output logic spec_q,
    output logic valid_q
);
    logic par_hit;
    logic spec_hit;

    assign par_hit  = char_valid & par_en & par_bad;
    assign spec_hit = char_valid & ((par_hit & par_spec_en) | overrun);

    always_ff @(posedge clk) begin
        if (rst || chan_rst) begin
            par_q   <= 1'b0;
            spec_q  <= 1'b0;
            valid_q <= 1'b0;
        end else begin
            par_q   <= par_hit  | (par_q  & ~err_reset);
            spec_q  <= spec_hit | (spec_q & ~err_reset);
            valid_q <= char_valid;
        end
    end

    // R1: a qualifying parity mismatch sets the bit
    assert_par_set_R1: assert property (@(posedge clk) disable iff (rst)
        (char_valid && par_en && par_bad && !chan_rst) |=> par_q);

    // R2: without a clearing command the bit holds
    assert_par_sticky_R2: assert property (@(posedge clk) disable iff (rst)
        (par_q && !err_reset && !chan_rst) |=> par_q);

    // R4: overrun raises the special condition
    assert_ovr_spec_R4: assert property (@(posedge clk) disable iff (rst)
        (char_valid && overrun && !chan_rst) |=> spec_q);

endmodule

// File: rtl/rx_residue_reg.sv
module rx_residue_reg
    import rx_stat_pkg::*;
#(
    parameter int W = RES_W,
    parameter logic [W-1:0] IDLE = RES_IDLE
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         chan_rst,
    input  chan_mode_e   mode,
    input  logic         char_valid,
    input  logic         eof,
    input  logic [W-1:0] res_in,
    output logic [W-1:0] res_q
);
    always_ff @(posedge clk) begin
        if (rst || chan_rst) begin
            res_q <= IDLE;
        end else if (mode != MODE_SDLC) begin
            res_q <= IDLE;
        end else if (char_valid) begin
            res_q <= eof ? res_in : IDLE;
        end
    end

    // R7: outside SDLC the field returns to the idle code
    assert_res_forced_R7: assert property (@(posedge clk) disable iff (rst)
        (mode != MODE_SDLC) |=> (res_q == IDLE));

endmodule

// File: rtl/rx_all_sent.sv
module rx_all_sent
    import rx_stat_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       chan_rst,
    input  chan_mode_e mode,
    input  logic       tx_idle,
    output logic       sent_q
);
    always_ff @(posedge clk) begin
        if (rst || chan_rst) sent_q <= 1'b1;
        else                 sent_q <= (mode != MODE_ASYNC) | tx_idle;
    end

    // R8: synchronous and SDLC modes always report all sent
    assert_sent_sync_R8: assert property (@(posedge clk) disable iff (rst)
        (mode != MODE_ASYNC) |=> sent_q);

endmodule

// File: rtl/rx_err_status.sv
module rx_err_status
    import rx_stat_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             chan_rst,
    input  logic [1:0]       mode,
    input  logic             par_en,
    input  logic             par_special_en,
    input  logic             err_reset,
    input  logic             rx_char_valid,
    input  logic             rx_par_bad,
    input  logic             rx_overrun,
    input  logic             rx_eof,
    input  logic [RES_W-1:0] rx_residue,
    input  logic             tx_idle,
    output logic [STAT_W-1:0] status,
    output logic             stat_valid,
    output logic             special_cond
);
    chan_mode_e       mode_e;
    logic             par_q;
    logic             spec_q;
    logic             valid_q;
    logic [RES_W-1:0] res_q;
    logic             sent_q;
    stat_byte_t       stat_s;

    assign mode_e = chan_mode_e'(mode);

    rx_err_latch u_err (
        .clk        (clk),
        .rst        (rst),
        .chan_rst   (chan_rst),
        .err_reset  (err_reset),
        .char_valid (rx_char_valid),
        .par_en     (par_en),
        .par_bad    (rx_par_bad),
        .par_spec_en(par_special_en),
        .overrun    (rx_overrun),
        .par_q      (par_q),
        .spec_q     (spec_q),
        .valid_q    (valid_q)
    );

    rx_residue_reg #(.W(RES_W), .IDLE(RES_IDLE)) u_res (
        .clk        (clk),
        .rst        (rst),
        .chan_rst   (chan_rst),
        .mode       (mode_e),
        .char_valid (rx_char_valid),
        .eof        (rx_eof),
        .res_in     (rx_residue),
        .res_q      (res_q)
    );

    rx_all_sent u_sent (
        .clk      (clk),
        .rst      (rst),
        .chan_rst (chan_rst),
        .mode     (mode_e),
        .tx_idle  (tx_idle),
        .sent_q   (sent_q)
    );

    assign stat_s       = pack_status(par_q, res_q, sent_q);
    assign status       = stat_s;
    assign stat_valid   = valid_q;
    assign special_cond = valid_q & spec_q;

    // R10: status strobe follows each character by one clock
    assert_valid_follow_R10: assert property (@(posedge clk) disable iff (rst)
        (rx_char_valid && !chan_rst) |=> stat_valid);

    // R5: a new overrun beats a same-cycle Error Reset
    assert_collide_R5: assert property (@(posedge clk) disable iff (rst)
        (rx_char_valid && rx_overrun && err_reset && !chan_rst) |=> special_cond);

    // R9: unused upper bits never show a one
    assert_upper_zero_R9: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (status[7:5] == 3'b000));

endmodule

// File: tb/rx_err_status_tb.sv
`timescale 1ns/1ps
module rx_err_status_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       chan_rst = 1'b0;
    logic [1:0] mode = 2'b00;
    logic       par_en = 1'b0;
    logic       par_special_en = 1'b0;
    logic       err_reset = 1'b0;
    logic       rx_char_valid = 1'b0;
    logic       rx_par_bad = 1'b0;
    logic       rx_overrun = 1'b0;
    logic       rx_eof = 1'b0;
    logic [2:0] rx_residue = 3'b000;
    logic       tx_idle = 1'b1;
    logic [7:0] status;
    logic       stat_valid;
    logic       special_cond;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    rx_err_status dut_i (
        .clk(clk), .rst(rst), .chan_rst(chan_rst), .mode(mode),
        .par_en(par_en), .par_special_en(par_special_en), .err_reset(err_reset),
        .rx_char_valid(rx_char_valid), .rx_par_bad(rx_par_bad),
        .rx_overrun(rx_overrun), .rx_eof(rx_eof), .rx_residue(rx_residue),
        .tx_idle(tx_idle), .status(status), .stat_valid(stat_valid),
        .special_cond(special_cond)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // one cycle of stimulus, then sample after the following rising edge
    task automatic step();
        @(negedge clk);
        rx_char_valid = 1'b0; rx_par_bad = 1'b0; rx_overrun = 1'b0;
        rx_eof = 1'b0; err_reset = 1'b0; chan_rst = 1'b0;
    endtask

    task automatic send(input logic pbad, input logic ovr, input logic eof, input logic [2:0] res);
        rx_char_valid = 1'b1; rx_par_bad = pbad; rx_overrun = ovr;
        rx_eof = eof; rx_residue = res;
        step();
    endtask

    task automatic do_err_reset();
        err_reset = 1'b1;
        step();
    endtask

    task automatic t_reset();
        chk("R6 reset status", status, 8'h07);
        chk("R6 reset valid", {7'b0, stat_valid}, 8'h00);
        chk("R6 reset special", {7'b0, special_cond}, 8'h00);
    endtask

    task automatic t_parity();
        par_en = 1'b0;
        send(1'b1, 1'b0, 1'b0, 3'b000);
        chk("R1 parity disabled", {7'b0, status[4]}, 8'h00);
        par_en = 1'b1;
        send(1'b1, 1'b0, 1'b0, 3'b000);
        chk("R1 parity set", {7'b0, status[4]}, 8'h01);
        chk("R10 strobe after char", {7'b0, stat_valid}, 8'h01);
        step();
        chk("R10 strobe one cycle", {7'b0, stat_valid}, 8'h00);
        chk("R2 sticky idle", {7'b0, status[4]}, 8'h01);
        send(1'b0, 1'b0, 1'b0, 3'b000);
        chk("R2 sticky clean char", {7'b0, status[4]}, 8'h01);
        do_err_reset();
        chk("R2 cleared by reset cmd", {7'b0, status[4]}, 8'h00);
    endtask

    task automatic t_par_special();
        par_special_en = 1'b0;
        send(1'b1, 1'b0, 1'b0, 3'b000);
        chk("R3 no special when disabled", {7'b0, special_cond}, 8'h00);
        do_err_reset();
        par_special_en = 1'b1;
        send(1'b1, 1'b0, 1'b0, 3'b000);
        chk("R3 special on error char", {7'b0, special_cond}, 8'h01);
        step();
        chk("R10 special low without strobe", {7'b0, special_cond}, 8'h00);
        send(1'b0, 1'b0, 1'b0, 3'b000);
        chk("R3 special on later char", {7'b0, special_cond}, 8'h01);
        do_err_reset();
        send(1'b0, 1'b0, 1'b0, 3'b000);
        chk("R3 special cleared", {7'b0, special_cond}, 8'h00);
        par_special_en = 1'b0;
    endtask

    task automatic t_overrun();
        send(1'b0, 1'b1, 1'b0, 3'b000);
        chk("R4 special on overrun", {7'b0, special_cond}, 8'h01);
        send(1'b0, 1'b0, 1'b0, 3'b000);
        chk("R4 special persists", {7'b0, special_cond}, 8'h01);
        do_err_reset();
        send(1'b0, 1'b0, 1'b0, 3'b000);
        chk("R4 special cleared", {7'b0, special_cond}, 8'h00);
    endtask

    task automatic t_collide();
        err_reset = 1'b1;
        send(1'b1, 1'b1, 1'b0, 3'b000);
        chk("R5 parity wins", {7'b0, status[4]}, 8'h01);
        chk("R5 overrun wins", {7'b0, special_cond}, 8'h01);
        do_err_reset();
    endtask

    task automatic t_residue();
        mode = 2'b10;
        send(1'b0, 1'b0, 1'b1, 3'b101);
        chk("R7 SDLC eof residue", {5'b0, status[3:1]}, 8'h05);
        send(1'b0, 1'b0, 1'b0, 3'b110);
        chk("R7 SDLC non-eof idle code", {5'b0, status[3:1]}, 8'h03);
        send(1'b1, 1'b0, 1'b1, 3'b100);
        chk("R9 full layout", status, 8'h19);
        mode = 2'b01;
        step();
        chk("R7 sync forces 011", {5'b0, status[3:1]}, 8'h03);
        mode = 2'b10;
        send(1'b0, 1'b0, 1'b1, 3'b000);
        chk("R7 SDLC residue 000", {5'b0, status[3:1]}, 8'h00);
        chan_rst = 1'b1;
        step();
        chk("R6 channel reset", status, 8'h07);
        send(1'b0, 1'b0, 1'b1, 3'b010);
        mode = 2'b00;
        step();
        chk("R7 async forces 011", {5'b0, status[3:1]}, 8'h03);
    endtask

    task automatic t_allsent();
        mode = 2'b00;
        tx_idle = 1'b0;
        step();
        chk("R8 async busy", {7'b0, status[0]}, 8'h00);
        tx_idle = 1'b1;
        step();
        chk("R8 async idle", {7'b0, status[0]}, 8'h01);
        tx_idle = 1'b0;
        mode = 2'b01;
        step();
        chk("R8 sync holds 1", {7'b0, status[0]}, 8'h01);
        mode = 2'b10;
        step();
        chk("R8 SDLC holds 1", {7'b0, status[0]}, 8'h01);
        tx_idle = 1'b1;
        mode = 2'b00;
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_parity();
        t_par_special();
        t_overrun();
        t_collide();
        t_residue();
        t_allsent();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule